// File: doc/BRIEF.md
# Execute-in-place cache gate

This block sits in front of a small direct-mapped cache that holds words of a flash device mapped for execute-in-place reads. Each bus access carries a two-bit window selector in its top address bits. Together with a three-bit control register, that selector decides what happens to the access. It can be answered from a cached line, fetched from flash (with or without filling the line), used to drop a line, silently discarded, answered with a bus error, or used to read or write the line storage directly as a scratch RAM.

The bus side is a valid/ready request port with a one-cycle response pulse that carries data and an error flag. The flash side is a single outstanding request held high until a one-cycle acknowledge returns the word. The control register is written through its own strobe, separate from the flash window, and reads back continuously. Its bits are: enable, fault-on-bad-write and sleep. While the block sleeps, the cache is forced off, but its line contents are kept.

Top module: `xip_cache_gate`

## Requirements
- R1: After reset the control read-back is 3'b011 (bit 0 enable = 1, bit 1 fault-on-bad-write = 1, bit 2 sleep = 0), no response or flash request is pending, and every line is invalid.
- R2: Address bits [25:24] select the window: 0 = cached with fill, 1 = cached without fill, 2 = uncached, 3 = scratch RAM. A read through window 2 always goes to flash, even when the word is cached.
- R3: While enable is 0, reads through windows 0 and 1 go to flash without a lookup, and they fill no line.
- R4: While enable is 1, a read through window 0 or 1 that hits a valid line with a matching tag is answered in the cycle after acceptance with the cached word, and no flash request is made.
- R5: A read miss through window 0 with enable set writes the fetched word, tag and valid bit into line addr[5:2]. A miss through window 1 leaves the line untouched.
- R6: A write through window 0 completes without error and without flash traffic, and it invalidates the indexed line when its tag matches, whatever the fault-on-bad-write bit holds.
- R7: A write through window 1 or 2 returns an error response when fault-on-bad-write is 1, and a clean response when it is 0. In both cases it changes no line and makes no flash request.
- R8: A control write with sleep (bit 2) set clears enable in the same write. No write with sleep set can leave enable at 1.
- R9: While sleep is 1, every scratch-RAM access (window 3) gets an error response. Line contents and tags survive, and they hit again once the block wakes up.
- R10: While awake, a scratch-RAM write stores the word in the data of line addr[5:2], and a scratch-RAM read returns it. Neither touches flash.
- R11: Each accepted request yields exactly one response. req_ready is low while a flash fetch is outstanding, and a miss is answered in the cycle after the flash acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control write value {sleep, fault, enable} |
| cfg_rdata | output | 3 | Control register read-back {sleep, fault, enable} |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high with valid |
| req_write | input | 1 | Request is a write |
| req_addr | input | 26 | Byte address; [25:24] select the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Response is a bus error |
| fl_req | output | 1 | Flash read request, held until acknowledged |
| fl_addr | output | 24 | Flash byte address |
| fl_ack | input | 1 | Flash acknowledge with data |
| fl_rdata | input | 32 | Flash read word |

## Verification
A hit, a drop, a fault, an invalidating write and a scratch-RAM access are all due one cycle after the accepting edge. The bench finds them at the first falling edge after that edge. A miss finishes one edge after the flash acknowledge. The flash model acknowledges on the third edge that sees the request, so every miss is expected at the fifth falling edge after acceptance. The bench counts flash acknowledges before and after each access, which shows whether the flash was touched. A control write is read back on the falling edge that follows its capturing edge.

// File: rtl/xipc_pkg.sv
package xipc_pkg;
   typedef enum logic [1:0] {
      WIN_ALLOC   = 2'd0,
      WIN_NOALLOC = 2'd1,
      WIN_DIRECT  = 2'd2,
      WIN_SCRATCH = 2'd3
   } win_e;

   typedef enum logic [2:0] {
      ACT_HIT,
      ACT_FETCH,
      ACT_INVAL,
      ACT_DROP,
      ACT_FAULT,
      ACT_SRAM_RD,
      ACT_SRAM_WR
   } act_e;

   typedef enum logic {
      ST_IDLE,
      ST_FETCH
   } fsm_e;

   typedef struct packed {
      logic sleep;
      logic fault_wr;
      logic en;
   } cfg_t;
endpackage

// File: rtl/xipc_cfg_reg.sv
module xipc_cfg_reg
   import xipc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [2:0] wdata,
   output cfg_t       cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.sleep    <= 1'b0;
         cfg.fault_wr <= 1'b1;
         cfg.en       <= 1'b1;
      end else if (wr) begin
         cfg.sleep    <= wdata[2];
         cfg.fault_wr <= wdata[1];
         cfg.en       <= wdata[0] & ~wdata[2];
      end
   end
endmodule

// File: rtl/xipc_steer_dec.sv
module xipc_steer_dec
   import xipc_pkg::*;
(
   input  win_e  win,
   input  logic  is_write,
   input  cfg_t  cfg,
   input  logic  hit,
   output act_e  act,
   output logic  fill
);
   always_comb begin
      act  = ACT_FETCH;
      fill = 1'b0;
      case (win)
         WIN_SCRATCH: begin
            if (cfg.sleep)     act = ACT_FAULT;
            else if (is_write) act = ACT_SRAM_WR;
            else               act = ACT_SRAM_RD;
         end
         WIN_DIRECT: begin
            if (is_write) act = cfg.fault_wr ? ACT_FAULT : ACT_DROP;
            else          act = ACT_FETCH;
         end
         WIN_NOALLOC: begin
            if (is_write)             act = cfg.fault_wr ? ACT_FAULT : ACT_DROP;
            else if (cfg.en && hit)   act = ACT_HIT;
            else                      act = ACT_FETCH;
         end
         default: begin
            if (is_write)             act = ACT_INVAL;
            else if (cfg.en && hit)   act = ACT_HIT;
            else begin
               act  = ACT_FETCH;
               fill = cfg.en;
            end
         end
      endcase
   end
endmodule

// File: rtl/xipc_line_store.sv
module xipc_line_store #(
   parameter int LINES  = 16,
   parameter int TAG_W  = 18,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              hit,
   output logic [DATA_W-1:0] rd_data,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              inval_en,
   input  logic [IDX_W-1:0]  inval_idx,
   input  logic              sram_we,
   input  logic [IDX_W-1:0]  sram_idx,
   input  logic [DATA_W-1:0] sram_wdata
);
   logic [LINES-1:0]  vld_vec;
   logic [TAG_W-1:0]  tag_arr [LINES];
   logic [DATA_W-1:0] dat_arr [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic              v_q;
      logic [TAG_W-1:0]  t_q;
      logic [DATA_W-1:0] d_q;
      wire fill_me  = fill_en  && (fill_idx  == IDX_W'(i));
      wire inval_me = inval_en && (inval_idx == IDX_W'(i));
      wire sram_me  = sram_we  && (sram_idx  == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        v_q <= 1'b0;
         else if (fill_me)  v_q <= 1'b1;
         else if (inval_me) v_q <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (fill_me) begin
            t_q <= fill_tag;
            d_q <= fill_data;
         end else if (sram_me) begin
            d_q <= sram_wdata;
         end
      end

      assign vld_vec[i] = v_q;
      assign tag_arr[i] = t_q;
      assign dat_arr[i] = d_q;
   end

   assign hit     = vld_vec[rd_idx] && (tag_arr[rd_idx] == rd_tag);
   assign rd_data = dat_arr[rd_idx];
endmodule

// File: rtl/xip_cache_gate.sv
module xip_cache_gate
   import xipc_pkg::*;
#(
   parameter int FLASH_AW = 24,
   parameter int ADDR_W   = 26,
   parameter int DATA_W   = 32,
   parameter int LINES    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_wdata,
   output logic [2:0]        cfg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err,
   output logic              fl_req,
   output logic [FLASH_AW-1:0] fl_addr,
   input  logic              fl_ack,
   input  logic [DATA_W-1:0] fl_rdata
);
   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = FLASH_AW - IDX_W - OFF_W;

   if (ADDR_W != FLASH_AW + 2) begin : g_bad_addr
      $error("ADDR_W must be FLASH_AW plus two window bits");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (DATA_W % 8 != 0 || TAG_W < 1) begin : g_bad_data
      $error("DATA_W must be whole bytes and leave a tag");
   end

   cfg_t             cfg;
   fsm_e             state;
   act_e             act;
   logic             fill;
   logic             hit;
   logic             accept;
   logic [1:0]       win_bits;
   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   logic [DATA_W-1:0] line_data;
   logic [FLASH_AW-1:0] fl_addr_q;
   logic             fill_q;
   logic [IDX_W-1:0] idx_q;
   logic [TAG_W-1:0] tag_q;

   assign win_bits  = req_addr[ADDR_W-1 -: 2];
   assign idx       = req_addr[OFF_W +: IDX_W];
   assign tag       = req_addr[OFF_W+IDX_W +: TAG_W];
   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign cfg_rdata = cfg;
   assign fl_req    = (state == ST_FETCH);
   assign fl_addr   = fl_addr_q;

   xipc_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   xipc_steer_dec u_dec (
      .win      (win_e'(win_bits)),
      .is_write (req_write),
      .cfg      (cfg),
      .hit      (hit),
      .act      (act),
      .fill     (fill)
   );

   xipc_line_store #(
      .LINES  (LINES),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (idx),
      .rd_tag     (tag),
      .hit        (hit),
      .rd_data    (line_data),
      .fill_en    (state == ST_FETCH && fl_ack && fill_q),
      .fill_idx   (idx_q),
      .fill_tag   (tag_q),
      .fill_data  (fl_rdata),
      .inval_en   (accept && act == ACT_INVAL && cfg.en && hit),
      .inval_idx  (idx),
      .sram_we    (accept && act == ACT_SRAM_WR),
      .sram_idx   (idx),
      .sram_wdata (req_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
         fl_addr_q <= '0;
         fill_q    <= 1'b0;
         idx_q     <= '0;
         tag_q     <= '0;
      end else begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         if (accept) begin
            rsp_data <= '0;
            case (act)
               ACT_HIT, ACT_SRAM_RD: begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= line_data;
               end
               ACT_FETCH: begin
                  state     <= ST_FETCH;
                  fl_addr_q <= req_addr[FLASH_AW-1:0];
                  fill_q    <= fill;
                  idx_q     <= idx;
                  tag_q     <= tag;
               end
               ACT_FAULT: begin
                  rsp_valid <= 1'b1;
                  rsp_err   <= 1'b1;
               end
               default: rsp_valid <= 1'b1;
            endcase
         end else if (state == ST_FETCH && fl_ack) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_data  <= fl_rdata;
         end
      end
   end
endmodule

// File: rtl/xipc_checker.sv
module xipc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       accept,
   input logic       req_write,
   input logic [1:0] win,
   input logic [2:0] cfg_rdata,
   input logic       hit,
   input logic       req_ready,
   input logic       rsp_valid,
   input logic       rsp_err,
   input logic       fl_req,
   input logic       fl_ack
);
   assert_sleep_forces_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[2] |-> !cfg_rdata[0]);

   assert_scratch_fault_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && win == 2'd3 && cfg_rdata[2]) |=> (rsp_valid && rsp_err));

   assert_hit_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_write && win[1] == 1'b0 && cfg_rdata[0] && hit)
      |=> (rsp_valid && !rsp_err && !fl_req));

   assert_off_goes_flash_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_write && win != 2'd3 && !cfg_rdata[0]) |=> fl_req);

   assert_badwrite_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_write && (win == 2'd1 || win == 2'd2) && cfg_rdata[1])
      |=> (rsp_valid && rsp_err && !fl_req));

   assert_ack_gives_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_ack) |=> (rsp_valid && !fl_req));

   assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |-> !req_ready);
endmodule

bind xip_cache_gate xipc_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .accept    (accept),
   .req_write (req_write),
   .win       (win_bits),
   .cfg_rdata (cfg_rdata),
   .hit       (hit),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .fl_req    (fl_req),
   .fl_ack    (fl_ack)
);

// File: tb/tb_xip_cache_gate.sv
`timescale 1ns/1ps
module tb_xip_cache_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_wdata = '0;
   logic [2:0]  cfg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [25:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        rsp_err;
   logic        fl_req;
   logic [23:0] fl_addr;
   logic        fl_ack = 1'b0;
   logic [31:0] fl_rdata = '0;

   int n_chk = 0;
   int n_err = 0;
   int fl_cnt = 0;
   int fl_wait = 0;
   bit done = 1'b0;

   logic [31:0] rd;
   bit          er;
   int          lat;

   localparam int MISS_LAT = 5;
   localparam logic [23:0] A_OFF = 24'h000104;
   localparam logic [23:0] B_OFF = 24'h000208;
   localparam logic [23:0] C_OFF = 24'h00030C;
   localparam logic [23:0] S_OFF = 24'h000014;

   always #10 clk = ~clk;

   xip_cache_gate dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .fl_req(fl_req), .fl_addr(fl_addr), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
   );

   function automatic logic [31:0] fdat(input logic [23:0] a);
      return {8'hC3, a} ^ 32'h0055_AA00;
   endfunction

   always @(posedge clk) begin
      fl_ack <= 1'b0;
      if (fl_req && !fl_ack) begin
         if (fl_wait == 2) begin
            fl_ack   <= 1'b1;
            fl_rdata <= fdat(fl_addr);
            fl_wait  <= 0;
            fl_cnt   <= fl_cnt + 1;
         end else begin
            fl_wait <= fl_wait + 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus(input bit wr, input logic [1:0] win, input logic [23:0] off,
                      input logic [31:0] wd);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = {win, off};
      req_wdata = wd;
      lat = 0; rd = '0; er = 1'b0;
      forever begin
         @(negedge clk);
         lat++;
         req_valid = 1'b0;
         if (rsp_valid) begin
            rd = rsp_data;
            er = rsp_err;
            break;
         end
         if (lat > 40) break;
      end
   endtask

   task automatic cfg_write(input logic [2:0] v);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic t_reset;
      check(cfg_rdata == 3'b011, "R1 reset cfg", 32'(cfg_rdata), 32'h3);
      check(!rsp_valid && !fl_req, "R1 idle outputs", {30'd0, rsp_valid, fl_req}, 32'h0);
   endtask

   task automatic t_fill;
      int c0;
      c0 = fl_cnt;
      bus(1'b0, 2'd0, A_OFF, '0);
      check(fl_cnt == c0 + 1, "R1 first read misses", 32'(fl_cnt - c0), 32'h1);
      check(rd == fdat(A_OFF) && !er, "R5 miss data", rd, fdat(A_OFF));
      check(lat == MISS_LAT, "R11 miss after ack", 32'(lat), 32'(MISS_LAT));
      c0 = fl_cnt;
      bus(1'b0, 2'd0, A_OFF, '0);
      check(lat == 1, "R4 hit latency", 32'(lat), 32'h1);
      check(rd == fdat(A_OFF) && fl_cnt == c0, "R4 hit data no flash", rd, fdat(A_OFF));
      c0 = fl_cnt;
      bus(1'b0, 2'd1, B_OFF, '0);
      bus(1'b0, 2'd1, B_OFF, '0);
      check(fl_cnt == c0 + 2, "R5 window1 no fill", 32'(fl_cnt - c0), 32'h2);
      bus(1'b0, 2'd0, B_OFF, '0);
      bus(1'b0, 2'd1, B_OFF, '0);
      check(lat == 1 && rd == fdat(B_OFF), "R2 window1 lookup hit", rd, fdat(B_OFF));
   endtask

   task automatic t_direct;
      int c0;
      c0 = fl_cnt;
      bus(1'b0, 2'd2, A_OFF, '0);
      check(fl_cnt == c0 + 1 && rd == fdat(A_OFF), "R2 uncached read",
            32'(fl_cnt - c0), 32'h1);
   endtask

   task automatic t_badwrite;
      int c0;
      c0 = fl_cnt;
      bus(1'b1, 2'd1, A_OFF, 32'h1111_2222);
      check(er && lat == 1, "R7 fault on window1 write", {31'd0, er}, 32'h1);
      bus(1'b0, 2'd0, A_OFF, '0);
      check(lat == 1 && rd == fdat(A_OFF) && fl_cnt == c0, "R7 line kept after fault",
            rd, fdat(A_OFF));
      cfg_write(3'b001);
      check(cfg_rdata == 3'b001, "R7 fault bit cleared", 32'(cfg_rdata), 32'h1);
      bus(1'b1, 2'd2, A_OFF, 32'h3333_4444);
      check(!er && lat == 1, "R7 silent drop", {31'd0, er}, 32'h0);
      bus(1'b0, 2'd0, A_OFF, '0);
      check(lat == 1 && rd == fdat(A_OFF) && fl_cnt == c0, "R7 line kept after drop",
            rd, fdat(A_OFF));
   endtask

   task automatic t_inval;
      int c0;
      c0 = fl_cnt;
      bus(1'b1, 2'd0, A_OFF, 32'h5555_6666);
      check(!er && lat == 1 && fl_cnt == c0, "R6 window0 write clean", {31'd0, er}, 32'h0);
      bus(1'b0, 2'd0, A_OFF, '0);
      check(lat == MISS_LAT && fl_cnt == c0 + 1, "R6 invalidated fault off",
            32'(lat), 32'(MISS_LAT));
      cfg_write(3'b011);
      bus(1'b1, 2'd0, B_OFF, 32'h0);
      check(!er, "R6 window0 write fault on", {31'd0, er}, 32'h0);
      c0 = fl_cnt;
      bus(1'b0, 2'd0, B_OFF, '0);
      check(fl_cnt == c0 + 1, "R6 invalidated fault on", 32'(fl_cnt - c0), 32'h1);
   endtask

   task automatic t_disable;
      int c0;
      cfg_write(3'b010);
      c0 = fl_cnt;
      bus(1'b0, 2'd0, A_OFF, '0);
      check(fl_cnt == c0 + 1 && lat == MISS_LAT, "R3 disabled bypass",
            32'(fl_cnt - c0), 32'h1);
      bus(1'b0, 2'd0, C_OFF, '0);
      cfg_write(3'b011);
      c0 = fl_cnt;
      bus(1'b0, 2'd0, C_OFF, '0);
      check(fl_cnt == c0 + 1, "R3 no fill while disabled", 32'(fl_cnt - c0), 32'h1);
      bus(1'b0, 2'd0, A_OFF, '0);
      check(lat == 1 && rd == fdat(A_OFF), "R3 line kept across disable", rd, fdat(A_OFF));
   endtask

   task automatic t_sram;
      int c0;
      c0 = fl_cnt;
      bus(1'b1, 2'd3, S_OFF, 32'hDEAD_BEEF);
      check(!er && lat == 1, "R10 scratch write", {31'd0, er}, 32'h0);
      bus(1'b0, 2'd3, S_OFF, '0);
      check(rd == 32'hDEAD_BEEF && !er && fl_cnt == c0, "R10 scratch read", rd, 32'hDEAD_BEEF);
   endtask

   task automatic t_sleep;
      int c0;
      cfg_write(3'b101);
      check(cfg_rdata == 3'b100, "R8 sleep clears enable", 32'(cfg_rdata), 32'h4);
      cfg_write(3'b111);
      check(cfg_rdata == 3'b110, "R8 enable blocked asleep", 32'(cfg_rdata), 32'h6);
      bus(1'b0, 2'd3, S_OFF, '0);
      check(er, "R9 scratch read error asleep", {31'd0, er}, 32'h1);
      bus(1'b1, 2'd3, S_OFF, 32'h0BAD_0BAD);
      check(er, "R9 scratch write error asleep", {31'd0, er}, 32'h1);
      c0 = fl_cnt;
      bus(1'b0, 2'd0, A_OFF, '0);
      check(fl_cnt == c0 + 1, "R9 asleep reads flash", 32'(fl_cnt - c0), 32'h1);
      cfg_write(3'b011);
      check(cfg_rdata == 3'b011, "R8 wake", 32'(cfg_rdata), 32'h3);
      bus(1'b0, 2'd0, A_OFF, '0);
      check(lat == 1 && rd == fdat(A_OFF), "R9 line retained", rd, fdat(A_OFF));
      bus(1'b0, 2'd3, S_OFF, '0);
      check(rd == 32'hDEAD_BEEF && !er, "R9 scratch retained", rd, 32'hDEAD_BEEF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_direct();
      t_badwrite();
      t_inval();
      t_disable();
      t_sram();
      t_sleep();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R11 watchdog actual=hung expected=complete");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule